// File: doc/BRIEF.md
# Register-Bank Bus Bridge with Access Checking

This block is a bus slave that sits between a single AHB-Lite style port and the register banks of up to four internal modules. It captures each address phase, splits the address into a module number and a register index, and then runs a simple handshake with the selected module. The bridge raises a one-hot request line together with the write flag and the register index, and waits for that module's ready or error strobe. While the module is working, the bus data phase is held in wait states.

Before any internal access starts, the bridge screens every transfer. A transfer that is not a 32-bit word, that is locked, that points at a module number with no bank behind it, or that touches a protected register while the supervisor input is low is refused with a two-cycle ERROR response, and no module sees it. An error strobe from a module, or a module that does not answer within a fixed number of cycles, also ends the transfer with ERROR. Burst type and protection attributes are not decoded, so a burst is handled as a series of single accesses. The bridge never issues split or retry.

The block is placed behind an external decoder that drives the select input for the bridge's address window. Only address bits 15 down to 2 are looked at.

Top module: `ahb_regbank_bridge`

## Requirements
- R1: Address bits 15:10 form the module number and bits 9:2 the register index that is presented on the index output. Bits 1:0 and all bits above 15 are ignored, and the burst and protection inputs have no effect on the result.
- R2: A read of a mapped, permitted register returns the data of the selected module with response OKAY (code 00) in the cycle in which HREADY goes high. A write forwards the write flag, the index and the data-phase write data to that module, and ends with OKAY.
- R3: A transfer whose size is not word (size code 010) ends with ERROR and raises no module request.
- R4: A transfer with the lock input high ends with ERROR and raises no module request.
- R5: A module number of 4 or more ends with ERROR and raises no module request.
- R6: An error strobe from the selected module ends the transfer with ERROR and drops the request. When ready and error arrive together, error wins.
- R7: Once the request is up, the module has 16 clock edges in which to give ready or error. A ready seen on the 16th edge still completes normally. With no answer by then, the request drops and the transfer ends with ERROR.
- R8: Register indices 128 to 255 (index bit 7 set) are protected. An access to one of them while the supervisor input is low ends with ERROR and raises no module request. With the supervisor input high, it proceeds normally.
- R9: An IDLE (00) or BUSY (01) transfer, or any cycle with the select input low, gets HREADY high with OKAY in the next cycle and starts no module access.
- R10: Every ERROR response takes two cycles: first HREADY low with response 01, then HREADY high with response 01. The response bit 1 is never set.
- R11: The active-low reset acts asynchronously. After reset and while idle, HREADY is high, the response is OKAY, and all module requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| supervisor | input | 1 | High grants access to protected registers |
| hsel | input | 1 | Slave select from the external decoder |
| haddr | input | 32 | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | High for write |
| hsize | input | 3 | Transfer size |
| hburst | input | 3 | Burst type (not decoded) |
| hprot | input | 4 | Protection attributes (not decoded) |
| hmastlock | input | 1 | Locked transfer flag |
| hready_in | input | 1 | Bus-wide ready, high when the previous data phase ends |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready_out | output | 1 | Registered ready of this slave |
| hresp | output | 2 | Registered response, 00 OKAY, 01 ERROR |
| hrdata | output | 32 | Registered read data |
| mod_req | output | 4 | One-hot request to the register modules |
| mod_we | output | 1 | Write flag of the pending request |
| mod_idx | output | 8 | Register index of the pending request |
| mod_wdata | output | 32 | Write data towards the modules |
| mod_rdy | input | 4 | Per-module ready strobe |
| mod_err | input | 4 | Per-module error strobe |
| mod_rdata | input | 128 | Read data of all modules, module n in bits 32n+31:32n |

## Verification
A state register that stayed in the waiting state would hold HREADY low without end. A stale module number would raise the wrong request bit, or return another module's data, in the first data-phase cycle. A wrong wait counter moves the ERROR of a silent module earlier or later than the 17th cycle after the address phase, so the bench checks latency 15 against latency 16 at that limit. A screening mistake shows as a request pulse on a module line in the cycle after the address phase. A broken error sequence shows as a single-cycle ERROR or an ERROR with HREADY high first.

// File: rtl/regbr_pkg.sv
package regbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_ERR1 = 2'd2,
        ST_ERR2 = 2'd3
    } regbr_state_e;

    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [1:0] RESP_ERROR = 2'b01;
    localparam logic [2:0] SIZE_WORD  = 3'b010;

endpackage

// File: rtl/regbr_decode.sv
module regbr_decode #(
    parameter int ADDR_W   = 32,
    parameter int NUM_MODS = 4,
    parameter int SEL_LO   = 10,
    parameter int SEL_W    = 6,
    parameter int IDX_W    = 8,
    localparam int MOD_W   = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1
) (
    input  logic [ADDR_W-1:0] haddr,
    input  logic [2:0]        hsize,
    input  logic              hmastlock,
    input  logic              supervisor,
    output logic [MOD_W-1:0]  mod_sel,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              reject
);
    import regbr_pkg::*;

    logic [SEL_W-1:0] sel_field;
    logic             bad_size;
    logic             unmapped;
    logic             prot_deny;
    logic             unused_addr;

    assign sel_field   = haddr[SEL_LO +: SEL_W];
    assign reg_idx     = haddr[2 +: IDX_W];
    assign mod_sel     = sel_field[MOD_W-1:0];
    assign unused_addr = ^{haddr[ADDR_W-1:SEL_LO+SEL_W], haddr[1:0]};

    always_comb begin
        bad_size  = (hsize != SIZE_WORD);
        unmapped  = (sel_field >= SEL_W'(NUM_MODS));
        prot_deny = reg_idx[IDX_W-1] && !supervisor;
        reject    = bad_size || hmastlock || unmapped || prot_deny;
    end

endmodule

// File: rtl/regbr_wait_timer.sv
module regbr_wait_timer #(
    parameter int LIMIT  = 16,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));

    always_comb begin
        cnt_d = '0;
        if (run && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R7: the wait count never passes the limit
    a_r7_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(LIMIT));

    // R7: leaving the wait state clears the count
    a_r7_cnt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/regbr_resp_mux.sv
module regbr_resp_mux #(
    parameter int NUM_MODS = 4,
    parameter int DATA_W   = 32,
    localparam int MOD_W   = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1
) (
    input  logic [MOD_W-1:0]           sel,
    input  logic [NUM_MODS-1:0]        mod_rdy,
    input  logic [NUM_MODS-1:0]        mod_err,
    input  logic [NUM_MODS*DATA_W-1:0] mod_rdata,
    output logic                       rdy_sel,
    output logic                       err_sel,
    output logic [DATA_W-1:0]          rdata_sel
);
    logic [NUM_MODS-1:0]             hit;
    logic [NUM_MODS-1:0][DATA_W-1:0] masked;

    for (genvar i = 0; i < NUM_MODS; i++) begin : g_mod
        assign hit[i]    = (sel == MOD_W'(i));
        assign masked[i] = hit[i] ? mod_rdata[i*DATA_W +: DATA_W] : '0;
    end

    assign rdy_sel = |(hit & mod_rdy);
    assign err_sel = |(hit & mod_err);

    always_comb begin
        rdata_sel = '0;
        for (int i = 0; i < NUM_MODS; i++) begin
            rdata_sel = rdata_sel | masked[i];
        end
    end

endmodule

// File: rtl/ahb_regbank_bridge.sv
module ahb_regbank_bridge #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_MODS = 4,
    parameter int SEL_LO   = 10,
    parameter int SEL_W    = 6,
    parameter int IDX_W    = 8,
    parameter int TIMEOUT  = 16,
    localparam int MOD_W   = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       supervisor,
    input  logic                       hsel,
    input  logic [ADDR_W-1:0]          haddr,
    input  logic [1:0]                 htrans,
    input  logic                       hwrite,
    input  logic [2:0]                 hsize,
    input  logic [2:0]                 hburst,
    input  logic [3:0]                 hprot,
    input  logic                       hmastlock,
    input  logic                       hready_in,
    input  logic [DATA_W-1:0]          hwdata,
    output logic                       hready_out,
    output logic [1:0]                 hresp,
    output logic [DATA_W-1:0]          hrdata,
    output logic [NUM_MODS-1:0]        mod_req,
    output logic                       mod_we,
    output logic [IDX_W-1:0]           mod_idx,
    output logic [DATA_W-1:0]          mod_wdata,
    input  logic [NUM_MODS-1:0]        mod_rdy,
    input  logic [NUM_MODS-1:0]        mod_err,
    input  logic [NUM_MODS*DATA_W-1:0] mod_rdata
);
    import regbr_pkg::*;

    typedef struct packed {
        regbr_state_e        st;
        logic [MOD_W-1:0]    sel;
        logic [IDX_W-1:0]    idx;
        logic                we;
        logic [NUM_MODS-1:0] req;
        logic                hready;
        logic [1:0]          hresp;
        logic [DATA_W-1:0]   rdata;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:     ST_IDLE,
        sel:    '0,
        idx:    '0,
        we:     1'b0,
        req:    '0,
        hready: 1'b1,
        hresp:  RESP_OKAY,
        rdata:  '0
    };

    regs_t r_d, r_q;

    logic [MOD_W-1:0]  dec_sel;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_reject;
    logic              rdy_sel;
    logic              err_sel;
    logic [DATA_W-1:0] rdata_sel;
    logic              wait_expired;
    logic              addr_phase;
    logic              in_busy;
    logic              unused_attr;

    assign unused_attr = ^{hburst, hprot};

    regbr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_MODS (NUM_MODS),
        .SEL_LO   (SEL_LO),
        .SEL_W    (SEL_W),
        .IDX_W    (IDX_W)
    ) i_decode (
        .haddr      (haddr),
        .hsize      (hsize),
        .hmastlock  (hmastlock),
        .supervisor (supervisor),
        .mod_sel    (dec_sel),
        .reg_idx    (dec_idx),
        .reject     (dec_reject)
    );

    regbr_resp_mux #(
        .NUM_MODS (NUM_MODS),
        .DATA_W   (DATA_W)
    ) i_resp_mux (
        .sel       (r_q.sel),
        .mod_rdy   (mod_rdy),
        .mod_err   (mod_err),
        .mod_rdata (mod_rdata),
        .rdy_sel   (rdy_sel),
        .err_sel   (err_sel),
        .rdata_sel (rdata_sel)
    );

    assign in_busy = (r_q.st == ST_BUSY);

    regbr_wait_timer #(
        .LIMIT (TIMEOUT)
    ) i_wait_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_busy),
        .expired (wait_expired)
    );

    assign addr_phase = hsel && htrans[1] && hready_in;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE, ST_ERR2: begin
                r_d.st     = ST_IDLE;
                r_d.hready = 1'b1;
                r_d.hresp  = RESP_OKAY;
                r_d.req    = '0;
                if (addr_phase) begin
                    r_d.rdata = '0;
                    if (dec_reject) begin
                        r_d.st     = ST_ERR1;
                        r_d.hready = 1'b0;
                        r_d.hresp  = RESP_ERROR;
                    end else begin
                        r_d.st     = ST_BUSY;
                        r_d.sel    = dec_sel;
                        r_d.idx    = dec_idx;
                        r_d.we     = hwrite;
                        r_d.req    = NUM_MODS'(1) << dec_sel;
                        r_d.hready = 1'b0;
                    end
                end
            end
            ST_BUSY: begin
                if (err_sel) begin
                    r_d.st    = ST_ERR1;
                    r_d.req   = '0;
                    r_d.hresp = RESP_ERROR;
                end else if (rdy_sel) begin
                    r_d.st     = ST_IDLE;
                    r_d.req    = '0;
                    r_d.hready = 1'b1;
                    r_d.hresp  = RESP_OKAY;
                    r_d.rdata  = r_q.we ? '0 : rdata_sel;
                end else if (wait_expired) begin
                    r_d.st    = ST_ERR1;
                    r_d.req   = '0;
                    r_d.hresp = RESP_ERROR;
                end
            end
            ST_ERR1: begin
                r_d.st     = ST_ERR2;
                r_d.hready = 1'b1;
                r_d.hresp  = RESP_ERROR;
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign hready_out = r_q.hready;
    assign hresp      = r_q.hresp;
    assign hrdata     = r_q.rdata;
    assign mod_req    = r_q.req;
    assign mod_we     = r_q.we;
    assign mod_idx    = r_q.idx;
    assign mod_wdata  = hwdata;

    // R10: first error cycle is always followed by the completing one
    a_r10_err_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready_out && hresp == RESP_ERROR) |=> (hready_out && hresp == RESP_ERROR));

    // R10: split and retry codes never appear
    a_r10_no_split_retry: assert property (@(posedge clk) disable iff (!rst_n)
        !hresp[1]);

    // R10: an ERROR with HREADY high is always preceded by HREADY low with ERROR
    a_r10_err_preceded: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_out && hresp == RESP_ERROR) |-> $past(!hready_out && hresp == RESP_ERROR));

    // R3: a size other than word never reaches a module
    a_r3_size_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_out && hsel && htrans[1] && hready_in && hsize != SIZE_WORD) |=> mod_req == '0);

    // R4: a locked transfer never reaches a module
    a_r4_lock_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_out && hsel && htrans[1] && hready_in && hmastlock) |=> mod_req == '0);

    // R9: no transfer means a zero-wait OKAY and no request
    a_r9_idle_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_out && !(hsel && htrans[1] && hready_in))
        |=> (hready_out && hresp == RESP_OKAY && mod_req == '0));

    // R6: a module error drops the request and starts the error response
    a_r6_err_passed: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req != '0 && |(mod_req & mod_err))
        |=> (mod_req == '0 && !hready_out && hresp == RESP_ERROR));

    // R2: at most one module is asked at a time, and only while HREADY is low
    a_r2_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_req) && (mod_req == '0 || !hready_out));

    // R7: a waiting request stays on the same module until it ends
    a_r7_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req != '0 && (mod_req & (mod_rdy | mod_err)) == '0 && !wait_expired)
        |=> $stable(mod_req));

endmodule

// File: tb/test_ahb_regbank_bridge.sv
`timescale 1ns/1ps
module test_ahb_regbank_bridge;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         supervisor = 1'b0;
    logic         hsel = 1'b0;
    logic [31:0]  haddr = '0;
    logic [1:0]   htrans = 2'b00;
    logic         hwrite = 1'b0;
    logic [2:0]   hsize = 3'b010;
    logic [2:0]   hburst = 3'b000;
    logic [3:0]   hprot = 4'b0000;
    logic         hmastlock = 1'b0;
    logic [31:0]  hwdata = '0;
    logic         hready_out;
    logic [1:0]   hresp;
    logic [31:0]  hrdata;
    logic [3:0]   mod_req;
    logic         mod_we;
    logic [7:0]   mod_idx;
    logic [31:0]  mod_wdata;
    logic [3:0]   mod_rdy = '0;
    logic [3:0]   mod_err = '0;
    logic [127:0] mod_rdata;

    always #2.5 clk = ~clk;

    ahb_regbank_bridge i_ahb_regbank_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .supervisor (supervisor),
        .hsel       (hsel),
        .haddr      (haddr),
        .htrans     (htrans),
        .hwrite     (hwrite),
        .hsize      (hsize),
        .hburst     (hburst),
        .hprot      (hprot),
        .hmastlock  (hmastlock),
        .hready_in  (hready_out),
        .hwdata     (hwdata),
        .hready_out (hready_out),
        .hresp      (hresp),
        .hrdata     (hrdata),
        .mod_req    (mod_req),
        .mod_we     (mod_we),
        .mod_idx    (mod_idx),
        .mod_wdata  (mod_wdata),
        .mod_rdy    (mod_rdy),
        .mod_err    (mod_err),
        .mod_rdata  (mod_rdata)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [1:0] m, input logic [7:0] idx);
        return 32'hC0DE_0000 | (32'(m) << 12) | {24'h0, idx};
    endfunction

    // register module models
    int          lat [4];
    logic        err_on [4];
    int          wait_n [4];
    logic        req_seen = 1'b0;
    logic [31:0] last_wdata = '0;
    logic [7:0]  last_idx = '0;
    int          last_mod = -1;

    for (genvar m = 0; m < 4; m++) begin : g_model
        assign mod_rdata[m*32 +: 32] = model_rd(2'(m), mod_idx);
    end

    initial begin
        for (int m = 0; m < 4; m++) begin
            lat[m] = 0; err_on[m] = 1'b0; wait_n[m] = 0;
        end
    end

    always @(negedge clk) begin
        if (|mod_req) req_seen = 1'b1;
        for (int m = 0; m < 4; m++) begin
            if (mod_req[m]) begin
                if (wait_n[m] == lat[m]) begin
                    if (err_on[m]) mod_err[m] = 1'b1;
                    else mod_rdy[m] = 1'b1;
                    if (mod_we) begin
                        last_wdata = mod_wdata;
                        last_idx   = mod_idx;
                        last_mod   = m;
                    end
                end else begin
                    mod_rdy[m] = 1'b0;
                    mod_err[m] = 1'b0;
                end
                wait_n[m]++;
            end else begin
                wait_n[m]  = 0;
                mod_rdy[m] = 1'b0;
                mod_err[m] = 1'b0;
            end
        end
    end

    // scoreboard
    typedef struct {
        logic        err;
        logic        chk_data;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   pend = 0;
    logic prev_hready = 1'b1;
    logic [1:0] prev_resp = 2'b00;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pend > 0 && hready_out) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected completion", 32'(hresp), 32'hX);
                end else begin
                    e = exp_q.pop_front();
                    check(hresp == (e.err ? 2'b01 : 2'b00), e.tag, 32'(hresp), e.err ? 32'd1 : 32'd0);
                    if (e.err) begin
                        check(!prev_hready && prev_resp == 2'b01, "R10 error first cycle",
                              {30'd0, prev_hready, prev_resp[0]}, 32'd1);
                    end
                    if (e.chk_data) begin
                        check(hrdata == e.data, {e.tag, " data"}, hrdata, e.data);
                    end
                end
                pend--;
            end
            if (hsel && htrans[1] && hready_out) pend++;
        end
        prev_hready = hready_out;
        prev_resp   = hresp;
    end

    task automatic xfer(input logic [31:0] addr, input logic wr, input logic [31:0] wd,
                        input logic [2:0] sz, input logic lk, input logic sup,
                        input logic [2:0] bst, input logic [3:0] prt,
                        input logic exp_err, input string tag);
        exp_t e;
        @(posedge clk); #1;
        hsel = 1'b1; haddr = addr; htrans = 2'b10; hwrite = wr; hsize = sz;
        hmastlock = lk; supervisor = sup; hburst = bst; hprot = prt;
        req_seen = 1'b0;
        e.err = exp_err;
        e.chk_data = !wr && !exp_err;
        e.data = model_rd(addr[11:10], addr[9:2]);
        e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk); #1;
        hsel = 1'b0; htrans = 2'b00; hwdata = wd; hmastlock = 1'b0; hsize = 3'b010;
        do @(negedge clk); while (!hready_out);
    endtask

    task automatic no_xfer(input logic sel, input logic [1:0] tr, input string tag);
        @(posedge clk); #1;
        hsel = sel; htrans = tr; haddr = 32'h0000_0004; req_seen = 1'b0;
        @(posedge clk); #1;
        hsel = 1'b0; htrans = 2'b00;
        @(negedge clk);
        check(hready_out && hresp == 2'b00 && !req_seen, tag,
              {29'd0, req_seen, hresp[0], hready_out}, 32'd1);
    endtask

    function automatic logic [31:0] mk_addr(input int m, input int idx);
        return (32'(m) << 10) | (32'(idx) << 2);
    endfunction

    initial begin
        #(5 * 20000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #7;
        @(negedge clk);
        check(hready_out && hresp == 2'b00 && mod_req == 4'h0, "R11 reset state",
              {27'd0, mod_req, hready_out}, 32'd1);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R2 R1: reads from different modules and indices
        xfer(mk_addr(0, 5), 1'b0, '0, 3'b010, 1'b0, 1'b0, 3'b000, 4'h0, 1'b0, "R2 read module 0");
        lat[3] = 3;
        xfer(mk_addr(3, 8'h7F) | 32'hABCD_0003, 1'b0, '0, 3'b010, 1'b0, 1'b0, 3'b011, 4'hF, 1'b0,
             "R1 ignored bits and attributes");
        // R2: write forwarding
        lat[2] = 1;
        xfer(mk_addr(2, 9), 1'b1, 32'h1234_5678, 3'b010, 1'b0, 1'b0, 3'b000, 4'h0, 1'b0, "R2 write module 2");
        check(last_wdata == 32'h1234_5678, "R2 write data", last_wdata, 32'h1234_5678);
        check(last_idx == 8'd9 && last_mod == 2, "R2 write index and module",
              {last_idx, 24'(last_mod)}, {8'd9, 24'd2});

        // R3: byte and halfword sizes
        xfer(mk_addr(1, 2), 1'b0, '0, 3'b000, 1'b0, 1'b0, 3'b000, 4'h0, 1'b1, "R3 byte size");
        check(!req_seen, "R3 no request on byte", 32'(req_seen), 32'd0);
        xfer(mk_addr(1, 2), 1'b1, 32'hFFFF, 3'b001, 1'b0, 1'b0, 3'b000, 4'h0, 1'b1, "R3 halfword size");
        check(!req_seen, "R3 no request on halfword", 32'(req_seen), 32'd0);

        // R4: locked
        xfer(mk_addr(0, 1), 1'b0, '0, 3'b010, 1'b1, 1'b0, 3'b000, 4'h0, 1'b1, "R4 locked transfer");
        check(!req_seen, "R4 no request on lock", 32'(req_seen), 32'd0);

        // R5: unmapped module numbers
        xfer(mk_addr(4, 0), 1'b0, '0, 3'b010, 1'b0, 1'b0, 3'b000, 4'h0, 1'b1, "R5 module 4");
        check(!req_seen, "R5 no request on module 4", 32'(req_seen), 32'd0);
        xfer(mk_addr(63, 3), 1'b1, 32'h1, 3'b010, 1'b0, 1'b0, 3'b000, 4'h0, 1'b1, "R5 module 63");

        // R6: module error
        err_on[1] = 1'b1; lat[1] = 2;
        xfer(mk_addr(1, 6), 1'b0, '0, 3'b010, 1'b0, 1'b0, 3'b000, 4'h0, 1'b1, "R6 module error");
        check(req_seen, "R6 request reached module", 32'(req_seen), 32'd1);
        err_on[1] = 1'b0;

        // R7: timeout boundary
        lat[1] = 15;
        xfer(mk_addr(1, 7), 1'b0, '0, 3'b010, 1'b0, 1'b0, 3'b000, 4'h0, 1'b0, "R7 ready on 16th edge");
        lat[1] = 16;
        xfer(mk_addr(1, 7), 1'b0, '0, 3'b010, 1'b0, 1'b0, 3'b000, 4'h0, 1'b1, "R7 no ready in time");
        @(negedge clk);
        check(mod_req == 4'h0, "R7 request dropped after timeout", 32'(mod_req), 32'd0);
        lat[1] = 0;
        xfer(mk_addr(1, 3), 1'b0, '0, 3'b010, 1'b0, 1'b0, 3'b000, 4'h0, 1'b0, "R7 recovery read");

        // R8: protected registers
        xfer(mk_addr(0, 8'h80), 1'b1, 32'hDEAD, 3'b010, 1'b0, 1'b0, 3'b000, 4'h0, 1'b1, "R8 protected denied");
        check(!req_seen, "R8 no request when denied", 32'(req_seen), 32'd0);
        xfer(mk_addr(0, 8'hFF), 1'b0, '0, 3'b010, 1'b0, 1'b1, 3'b000, 4'h0, 1'b0, "R8 protected with supervisor");
        xfer(mk_addr(0, 8'h7F), 1'b0, '0, 3'b010, 1'b0, 1'b0, 3'b000, 4'h0, 1'b0, "R8 index 127 open");

        // R9: no-transfer cycles
        no_xfer(1'b1, 2'b00, "R9 IDLE transfer");
        no_xfer(1'b1, 2'b01, "R9 BUSY transfer");
        no_xfer(1'b0, 2'b10, "R9 deselected NONSEQ");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && pend == 0, "R10 all responses seen", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule